// File: doc/BRIEF.md
# Frame RAM Pixel Streaming Controller

This block walks an image held in a block RAM. The image is stored as 16-bit RGB565 pixels, two to a 32-bit word, with the lower-indexed pixel in bits 15:0. The block feeds each pixel into an external processing pipeline and writes the pipeline's result back into the word it came from. That pipeline is combinational within one clock. A frame begins when a start request is seen in idle. Width and height are sampled at that moment. The block ends the frame with a one-cycle done pulse.

The parameter `DUAL_LANE` selects one of two build variants. With `DUAL_LANE = 0` there is one lane, and the two halves of a word pass through it in turn over a fixed 9-cycle sequence. With `DUAL_LANE = 1` both halves pass through two lanes together over a 5-cycle sequence. Every read and every write step lasts two cycles, which leaves margin for RAM timing. The RAM has one port with synchronous read, one-cycle read latency and per-byte write enables.

Top module: `frame_walker`

## Requirements
- R1: After reset, `frame_done` is 0, `ram_we` is 4'b0000 and `ram_addr` is 0.
- R2: A start request is accepted only while idle. A start request during a frame does not change that frame's length, its written data or its done timing.
- R3: With `DUAL_LANE = 0`, each word takes exactly 9 cycles. A frame of N words raises `frame_done` 9·N clock edges after the edge that accepted the start.
- R4: With `DUAL_LANE = 1`, each word takes exactly 5 cycles. A frame of N words raises `frame_done` 5·N edges after the accepting edge.
- R5: `ram_addr` is steady within a word and `ram_we` is 0 in the address cycle. In serial mode the low-half write uses enables 4'b0011 (bytes 0–1), the high-half write uses 4'b1100 (bytes 2–3), and each write lasts two consecutive cycles with the same enables. In dual mode the write uses 4'b1111.
- R6: Each returned pixel is written to the same half of the same word it was read from. Serial mode sends the low half and then the high half on lane 0. Dual mode sends the low half on lane 0 and the high half on lane 1.
- R7: N = ceil(W·H/2) words, from word 0 upward, are processed. Words at and above N are left unchanged.
- R8: When W·H is odd, the high half of the last word keeps its original value.
- R9: `frame_done` lasts exactly one cycle, and `ram_addr` is 0 while it is high.
- R10: If W·H is 0, a start request gives `frame_done` on the accepting edge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Frame start request |
| frame_w | input | DIM_W | Frame width in pixels |
| frame_h | input | DIM_W | Frame height in pixels |
| ram_addr | output | ADDR_W | Word address |
| ram_we | output | 4 | Byte write enables |
| ram_wdata | output | 32 | Write data |
| ram_rdata | input | 32 | Read data, one cycle after address |
| lane0_out | output | 16 | Pixel to pipeline lane 0 |
| lane0_in | input | 16 | Processed pixel from lane 0 |
| lane1_out | output | 16 | Pixel to pipeline lane 1 (dual mode) |
| lane1_in | input | 16 | Processed pixel from lane 1 (dual mode) |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds two instances side by side, one with `DUAL_LANE = 0` and one with `DUAL_LANE = 1`. Each has `DIM_W = 8` and `ADDR_W = 6` and is backed by its own 64-word RAM model. Both instances run the same frames, so the 9-cycle and 5-cycle sequences are checked against identical data. The small RAM brings several cases within reach: a frame that fills every word, odd pixel counts that leave a half-used last word, words above the frame that must stay untouched, and a zero-area frame.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR,
    ST_RL1, ST_RL2, ST_WL1, ST_WL2,
    ST_RH1, ST_RH2, ST_WH1, ST_WH2
  } fw_state_e;
endpackage

// File: rtl/fw_seq.sv
module fw_seq
  import fw_pkg::*;
#(
  parameter int DIM_W     = 9,
  parameter int ADDR_W    = 15,
  parameter bit DUAL_LANE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  output fw_state_e         st,
  output logic [ADDR_W-1:0] word_addr,
  output logic              odd_tail,
  output logic              frame_done
);
  localparam int PROD_W = 2 * DIM_W;
  localparam fw_state_e LAST_ST = DUAL_LANE ? ST_WL2 : ST_WH2;

  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   prod_p1;
  logic [PROD_W-1:0] word_idx, nwords_q;
  logic              odd_q, last_word;
  logic              unused_idx;

  assign prod      = PROD_W'(frame_w) * PROD_W'(frame_h);
  assign prod_p1   = {1'b0, prod} + 1'b1;
  assign last_word = (word_idx == nwords_q - 1'b1);
  assign odd_tail  = odd_q && last_word;
  assign word_addr = word_idx[ADDR_W-1:0];
  assign unused_idx = ^word_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      word_idx   <= '0;
      nwords_q   <= '0;
      odd_q      <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        ST_IDLE: if (start_req) begin
          nwords_q <= prod_p1[PROD_W:1];
          odd_q    <= prod[0];
          word_idx <= '0;
          if (prod == '0) frame_done <= 1'b1;
          else            st <= ST_ADDR;
        end
        ST_ADDR: st <= ST_RL1;
        ST_RL1:  st <= ST_RL2;
        ST_RL2:  st <= ST_WL1;
        ST_WL1:  st <= ST_WL2;
        ST_WL2:  st <= DUAL_LANE ? ST_ADDR : ST_RH1;
        ST_RH1:  st <= ST_RH2;
        ST_RH2:  st <= ST_WH1;
        ST_WH1:  st <= ST_WH2;
        default: st <= ST_ADDR;
      endcase
      if (st == LAST_ST) begin
        if (last_word) begin
          st         <= ST_IDLE;
          word_idx   <= '0;
          frame_done <= 1'b1;
        end else begin
          st       <= ST_ADDR;
          word_idx <= word_idx + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_done_addr_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> word_addr == '0);
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start_req) |=> $stable(nwords_q));
  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != LAST_ST) |=> $stable(word_addr));
endmodule

// File: rtl/fw_datapath.sv
module fw_datapath
  import fw_pkg::*;
#(
  parameter bit DUAL_LANE = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  fw_state_e   st,
  input  logic        odd_tail,
  input  logic [31:0] ram_rdata,
  input  logic [15:0] lane0_in,
  input  logic [15:0] lane1_in,
  output logic [15:0] lane0_out,
  output logic [15:0] lane1_out,
  output logic [3:0]  ram_we,
  output logic [31:0] ram_wdata
);
  logic [31:0] word_q, src;
  logic        first_rd, active;

  assign first_rd = (st == ST_RL1) || (st == ST_RH1);
  assign active   = (st != ST_IDLE) && (st != ST_ADDR);
  assign src      = first_rd ? ram_rdata : word_q;

  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (first_rd) word_q <= ram_rdata;
  end

  generate
    if (DUAL_LANE) begin : g_dual
      logic wr;
      assign wr        = (st == ST_WL1) || (st == ST_WL2);
      assign lane0_out = active ? src[15:0]  : '0;
      assign lane1_out = active ? src[31:16] : '0;
      assign ram_we    = wr ? 4'b1111 : 4'b0000;
      assign ram_wdata = {odd_tail ? word_q[31:16] : lane1_in, lane0_in};
    end else begin : g_serial
      logic hi, wr_lo, wr_hi;
      logic unused_l1;
      assign unused_l1 = ^lane1_in;
      assign hi        = (st == ST_RH1) || (st == ST_RH2) ||
                         (st == ST_WH1) || (st == ST_WH2);
      assign wr_lo     = (st == ST_WL1) || (st == ST_WL2);
      assign wr_hi     = (st == ST_WH1) || (st == ST_WH2);
      assign lane0_out = !active ? '0 : (hi ? src[31:16] : src[15:0]);
      assign lane1_out = '0;
      assign ram_we    = wr_lo ? 4'b0011 : (wr_hi ? 4'b1100 : 4'b0000);
      assign ram_wdata = wr_hi ? {odd_tail ? word_q[31:16] : lane0_in, word_q[15:0]}
                               : {word_q[31:16], lane0_in};
    end
  endgenerate

  assert_addr_cycle_no_we_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR) |-> ram_we == 4'b0000);
  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(|ram_we) |=> ram_we == $past(ram_we));
  assert_we_legal_R5: assert property (@(posedge clk) disable iff (rst)
    DUAL_LANE ? (ram_we == 4'b0000 || ram_we == 4'b1111)
              : (ram_we == 4'b0000 || ram_we == 4'b0011 || ram_we == 4'b1100));
endmodule

// File: rtl/frame_walker.sv
module frame_walker
  import fw_pkg::*;
#(
  parameter int DIM_W     = 9,
  parameter int ADDR_W    = 15,
  parameter bit DUAL_LANE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [3:0]        ram_we,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic [15:0]       lane0_out,
  input  logic [15:0]       lane0_in,
  output logic [15:0]       lane1_out,
  input  logic [15:0]       lane1_in,
  output logic              frame_done
);
  fw_state_e st;
  logic      odd_tail;

  fw_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .DUAL_LANE(DUAL_LANE)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req),
    .frame_w(frame_w), .frame_h(frame_h),
    .st(st), .word_addr(ram_addr), .odd_tail(odd_tail),
    .frame_done(frame_done)
  );

  fw_datapath #(.DUAL_LANE(DUAL_LANE)) u_dp (
    .clk(clk), .rst(rst), .st(st), .odd_tail(odd_tail),
    .ram_rdata(ram_rdata), .lane0_in(lane0_in), .lane1_in(lane1_in),
    .lane0_out(lane0_out), .lane1_out(lane1_out),
    .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!frame_done && ram_we == 4'b0000 && ram_addr == '0));
endmodule

// File: tb/frame_walker_bench.sv
module frame_walker_bench;
  localparam int DIM_W = 8;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [DIM_W-1:0] fw = '0, fh = '0;
  always #5 clk = ~clk;

  logic [AW-1:0] a0, a1;
  logic [3:0]    we0, we1;
  logic [31:0]   wd0, wd1, rd0, rd1;
  logic [15:0]   l0o_s, l0i_s, l1o_s, l1i_s;
  logic [15:0]   l0o_d, l0i_d, l1o_d, l1i_d;
  logic          done0, done1;

  logic [31:0] mem0 [DEPTH];
  logic [31:0] mem1 [DEPTH];
  logic [31:0] orig [DEPTH];
  logic        ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] pipe_f(input logic [15:0] x);
    return {x[7:0], x[15:8]} ^ 16'h5A3C;
  endfunction

  assign l0i_s = pipe_f(l0o_s);
  assign l1i_s = pipe_f(l1o_s);
  assign l0i_d = pipe_f(l0o_d);
  assign l1i_d = pipe_f(l1o_d);

  always @(posedge clk) begin
    if (ld_en) mem0[ld_addr] <= ld_data;
    else for (int b = 0; b < 4; b++) if (we0[b]) mem0[a0][8*b +: 8] <= wd0[8*b +: 8];
    rd0 <= mem0[a0];
  end
  always @(posedge clk) begin
    if (ld_en) mem1[ld_addr] <= ld_data;
    else for (int b = 0; b < 4; b++) if (we1[b]) mem1[a1][8*b +: 8] <= wd1[8*b +: 8];
    rd1 <= mem1[a1];
  end

  frame_walker #(.DIM_W(DIM_W), .ADDR_W(AW), .DUAL_LANE(1'b0)) u_frame_walker (
    .clk(clk), .rst(rst), .start_req(start_req), .frame_w(fw), .frame_h(fh),
    .ram_addr(a0), .ram_we(we0), .ram_wdata(wd0), .ram_rdata(rd0),
    .lane0_out(l0o_s), .lane0_in(l0i_s), .lane1_out(l1o_s), .lane1_in(l1i_s),
    .frame_done(done0)
  );

  frame_walker #(.DIM_W(DIM_W), .ADDR_W(AW), .DUAL_LANE(1'b1)) u_frame_walker_dual (
    .clk(clk), .rst(rst), .start_req(start_req), .frame_w(fw), .frame_h(fh),
    .ram_addr(a1), .ram_we(we1), .ram_wdata(wd1), .ram_rdata(rd1),
    .lane0_out(l0o_d), .lane0_in(l0i_d), .lane1_out(l1o_d), .lane1_in(l1i_d),
    .frame_done(done1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_frame(input bit random_fill);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i);
      ld_data = random_fill ? $urandom : {16'(i * 3 + 1), 16'(i * 7 + 2)};
      orig[i] = ld_data;
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run_frame(input int w, input int h, input bit poke);
    int n, total, c0, c1, cnt;
    logic [31:0] e;
    logic [15:0] ehi;
    bit seen0, seen1;
    load_frame(1'b1);
    total = w * h; n = (total + 1) / 2;
    fw = DIM_W'(w); fh = DIM_W'(h);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    cnt = 0; c0 = -1; c1 = -1; seen0 = 0; seen1 = 0;
    if (done0) begin seen0 = 1; c0 = 0; check("R9 addr zero at done", 32'(a0), 0); end
    if (done1) begin seen1 = 1; c1 = 0; end
    while (!(seen0 && seen1) && cnt < 2000) begin
      @(negedge clk); cnt++;
      start_req = poke && (cnt == 7);
      if (done0 && !seen0) begin
        seen0 = 1; c0 = cnt;
        check("R9 addr zero at done", 32'(a0), 0);
      end
      if (done1 && !seen1) begin seen1 = 1; c1 = cnt; end
    end
    start_req = 1'b0;
    @(negedge clk);
    check("R9 done one cycle", {31'b0, done0 | done1}, 0);
    check(total == 0 ? "R10 zero area done" : "R3 serial cycles", 32'(c0), 32'(9 * n));
    check(total == 0 ? "R10 zero area done" : "R4 dual cycles", 32'(c1), 32'(5 * n));
    if (poke) check("R2 start while busy ignored", 32'(c0), 32'(9 * n));
    for (int i = 0; i < DEPTH; i++) begin
      if (i < n) begin
        ehi = (2 * i + 1 < total) ? pipe_f(orig[i][31:16]) : orig[i][31:16];
        e = {ehi, pipe_f(orig[i][15:0])};
      end else e = orig[i];
      if (i == n - 1 && total % 2 == 1) begin
        check("R8 odd tail serial", mem0[i], e);
        check("R8 odd tail dual", mem1[i], e);
      end else if (i < n) begin
        check("R6 serial write-back", mem0[i], e);
        check("R6 dual write-back", mem1[i], e);
      end else begin
        check(total == 0 ? "R10 no write" : "R7 untouched serial", mem0[i], e);
        check("R7 untouched dual", mem1[i], e);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w, h;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done low", {31'b0, done0 | done1}, 0);
    check("R1 we zero", {24'b0, we0, we1}, 0);
    check("R1 addr zero", {20'b0, a0, a1}, 0);
    // serial write enables: watch a word in flight (R5)
    load_frame(1'b0);
    fw = 8'd2; fh = 8'd2;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check("R5 addr cycle no write", {28'b0, we0}, 0);
    repeat (3) @(negedge clk);
    check("R5 low write enables", {28'b0, we0}, 32'h3);
    check("R5 dual write enables", {28'b0, we1}, 32'hF);
    @(negedge clk);
    check("R5 low write held", {28'b0, we0}, 32'h3);
    check("R6 serial lane0 low pixel", {16'b0, l0o_s}, {16'b0, orig[0][15:0]});
    repeat (4) @(negedge clk);
    check("R5 high write enables", {28'b0, we0}, 32'hC);
    check("R6 serial lane0 high pixel", {16'b0, l0o_s}, {16'b0, orig[0][31:16]});
    repeat (30) @(negedge clk);
    run_frame(1, 1, 1'b0);
    run_frame(2, 1, 1'b0);
    run_frame(3, 3, 1'b0);
    run_frame(8, 16, 1'b0);
    run_frame(0, 5, 1'b0);
    run_frame(5, 5, 1'b1);
    for (int k = 0; k < 6; k++) begin
      w = 1 + int'($urandom % 12);
      h = 1 + int'($urandom % 10);
      run_frame(w, h, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule